// File: doc/BRIEF.md
# Transcoder Serial Frame Interface

This block is the serial front end of one voice-band transcoder channel. It runs on a master clock and is framed by an active-low strobe. Every falling edge of the strobe captures a mode bit and a two-bit rate select. Both apply to the word that was shifted in during the frame just ended. Two serial clocks, neither related to the master clock, carry the two data formats. The compressed-code clock carries a 2- to 5-bit code. The sample clock carries an 8-bit companded sample. In decode mode a code comes in and a sample goes out. In encode mode a sample comes in and a code goes out.

Each serial clock, each serial input and the strobe pass through a synchronizer. Their edges are detected in the master-clock domain. A captured word is converted during the following frame and shifted out during the frame after that. The conversion arithmetic is stood in for by a fixed stub, so only the framing, the word lengths and the latency are real. Serial clocks must run at no more than a quarter of the master clock. The strobe must stay low for more than four master-clock cycles.

Top module: `xcode_serial_if`

## Requirements
- R1: On each detected falling edge of `ce_n`, the block captures `mode_i` and `rate_i` together with the word shifted in before that edge. The captured word's result is shifted out in the frame that begins at the next falling edge of `ce_n`.
- R2: `rate_i` sets the code length. 2'b00 gives 4 bits, 2'b01 gives 3 bits, 2'b10 gives 2 bits and 2'b11 gives 5 bits.
- R3: With `mode_i`=0 (decode), `a_sdi` is sampled on falling edges of `a_sclk` into a 5-bit register, MSB first. Only the last code-length bits are used, placed left-aligned with zeros below.
- R4: A decoded result is the aligned code followed by three zero bits, XOR 8'hA5. It is driven on `p_sdo` MSB first, one bit per rising edge of `p_sclk`, eight bits in total.
- R5: With `mode_i`=1 (encode), `p_sdi` is sampled on falling edges of `p_sclk`, MSB first. The result is the top five sample bits XOR 5'h15, with only the top code-length bits kept. It is driven on `a_sdo` MSB first, one bit per rising edge of `a_sclk`.
- R6: Both outputs are forced to 0 when a frame starts. They drive 0 on every rising edge of their clock once the word is exhausted. The pin not used by the frame's mode stays 0 for the whole frame.
- R7: An output changes only in the cycle after a synchronized edge of its own serial clock or of the strobe.
- R8: After reset both outputs are 0, and the first frame after reset shifts out nothing.
- R9: Mode and rate may change from frame to frame. Each word is handled with its own captured control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| ce_n | input | 1 | frame strobe, falling edge starts a frame |
| mode_i | input | 1 | 0 decode, 1 encode |
| rate_i | input | 2 | code length select |
| a_sclk | input | 1 | compressed-code serial clock |
| a_sdi | input | 1 | compressed-code serial input |
| a_sdo | output | 1 | compressed-code serial output |
| p_sclk | input | 1 | sample serial clock |
| p_sdi | input | 1 | sample serial input |
| p_sdo | output | 1 | sample serial output |

## Verification
A word sent in one frame yields its result two strobe falls later. The bench model therefore carries each word and its control through a two-frame pipeline before it queues the expected pin patterns. Each output bit follows its serial clock's rising edge by the synchronizer depth plus one register, about four master cycles. The bench samples it seven cycles after the rise, on the falling master edge, well inside the half period. Input bits are set at the rising edge and stay stable until the falling edge eight cycles later, so the synchronized data is settled when it is sampled.

// File: rtl/xsi_pkg.sv
package xsi_pkg;
  typedef enum logic [1:0] {
    RATE_32 = 2'b00,
    RATE_24 = 2'b01,
    RATE_16 = 2'b10,
    RATE_40 = 2'b11
  } rate_e;

  // code length for a rate, relative to the full code width
  function automatic int unsigned code_len(rate_e r, int unsigned full);
    case (r)
      RATE_32: return full - 1;
      RATE_24: return full - 2;
      RATE_16: return full - 3;
      default: return full;
    endcase
  endfunction
endpackage

// File: rtl/xsi_sync.sv
module xsi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/xsi_shin.sv
module xsi_shin #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         bit_i,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)       word <= '0;
    else if (step) word <= {word[W-2:0], bit_i};
  end
endmodule

// File: rtl/xsi_shout.sv
module xsi_shout #(
  parameter int W     = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     word,
  input  logic [CNT_W-1:0] len,
  input  logic             step,
  output logic             pin
);
  logic [W-1:0]     sr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
      pin <= 1'b0;
    end else if (load) begin
      sr  <= word;
      cnt <= len;
      pin <= 1'b0;
    end else if (step) begin
      if (cnt != '0) begin
        pin <= sr[W-1];
        sr  <= {sr[W-2:0], 1'b0};
        cnt <= cnt - 1'b1;
      end else begin
        pin <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xcode_serial_if.sv
module xcode_serial_if #(
  parameter int          PCM_W       = 8,
  parameter int          CODE_W      = 5,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  DEC_XOR     = 8'hA5,
  parameter logic [4:0]  ENC_XOR     = 5'h15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       mode_i,
  input  logic [1:0] rate_i,
  input  logic       a_sclk,
  input  logic       a_sdi,
  output logic       a_sdo,
  input  logic       p_sclk,
  input  logic       p_sdi,
  output logic       p_sdo
);
  import xsi_pkg::*;

  localparam int CNT_W = $clog2(PCM_W + 1);
  localparam int PAD_W = PCM_W - CODE_W;
  localparam int NSIG  = 5;
  localparam int I_CE = 4, I_AC = 3, I_AD = 2, I_PC = 1, I_PD = 0;

  // synchronizers for strobe, both serial clocks and both serial inputs
  logic [NSIG-1:0] s_q, s_rise, s_fall;
  xsi_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ce_n, a_sclk, a_sdi, p_sclk, p_sdi}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );

  logic ce_fall, a_rise, a_fall, p_rise, p_fall;
  assign ce_fall = s_fall[I_CE];
  assign a_rise  = s_rise[I_AC];
  assign a_fall  = s_fall[I_AC];
  assign p_rise  = s_rise[I_PC];
  assign p_fall  = s_fall[I_PC];

  // input shift registers, always running on their clocks' falling edges
  logic [CODE_W-1:0] code_sr;
  logic [PCM_W-1:0]  pcm_sr;
  xsi_shin #(.W(CODE_W)) u_code_in (
    .clk(clk), .rst(rst), .step(a_fall), .bit_i(s_q[I_AD]), .word(code_sr));
  xsi_shin #(.W(PCM_W)) u_pcm_in (
    .clk(clk), .rst(rst), .step(p_fall), .bit_i(s_q[I_PD]), .word(pcm_sr));

  // alignment of the received code by the incoming rate
  logic [CNT_W-1:0]  in_len, in_sh;
  logic [CODE_W-1:0] code_aligned;
  always_comb begin
    in_len       = CNT_W'(code_len(rate_e'(rate_i), CODE_W));
    in_sh        = CNT_W'(CODE_W) - in_len;
    code_aligned = code_sr << in_sh;
  end

  // capture stage: control and word taken at the strobe's falling edge
  logic             cap_valid, cap_mode;
  logic [1:0]       cap_rate;
  logic [PCM_W-1:0] cap_word;
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_mode  <= 1'b0;
      cap_rate  <= '0;
      cap_word  <= '0;
    end else if (ce_fall) begin
      cap_valid <= 1'b1;
      cap_mode  <= mode_i;
      cap_rate  <= rate_i;
      cap_word  <= mode_i ? pcm_sr : {code_aligned, {PAD_W{1'b0}}};
    end
  end

  // conversion stub, registered during the frame after capture
  logic [CNT_W-1:0]  cv_len;
  logic [CODE_W-1:0] cv_mask, enc_res;
  logic [PCM_W-1:0]  dec_res;
  always_comb begin
    cv_len  = CNT_W'(code_len(rate_e'(cap_rate), CODE_W));
    cv_mask = ~({CODE_W{1'b1}} >> cv_len);
    enc_res = (cap_word[PCM_W-1 -: CODE_W] ^ ENC_XOR[CODE_W-1:0]) & cv_mask;
    dec_res = cap_word ^ DEC_XOR[PCM_W-1:0];
  end

  logic [CODE_W-1:0] cv_code;
  logic [PCM_W-1:0]  cv_pcm;
  logic [CNT_W-1:0]  cv_a_len, cv_p_len;
  always_ff @(posedge clk) begin
    if (rst) begin
      cv_code  <= '0;
      cv_pcm   <= '0;
      cv_a_len <= '0;
      cv_p_len <= '0;
    end else begin
      cv_code  <= enc_res;
      cv_pcm   <= dec_res;
      cv_a_len <= (cap_valid &&  cap_mode) ? cv_len : '0;
      cv_p_len <= (cap_valid && !cap_mode) ? CNT_W'(PCM_W) : '0;
    end
  end

  // output shifters, loaded at the strobe's falling edge
  xsi_shout #(.W(CODE_W), .CNT_W(CNT_W)) u_code_out (
    .clk(clk), .rst(rst), .load(ce_fall), .word(cv_code), .len(cv_a_len),
    .step(a_rise), .pin(a_sdo));
  xsi_shout #(.W(PCM_W), .CNT_W(CNT_W)) u_pcm_out (
    .clk(clk), .rst(rst), .load(ce_fall), .word(cv_pcm), .len(cv_p_len),
    .step(p_rise), .pin(p_sdo));
endmodule

// File: rtl/xcode_serial_if_chk.sv
module xcode_serial_if_chk #(
  parameter int PCM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_fall,
  input logic             a_rise,
  input logic             p_rise,
  input logic             a_sdo,
  input logic             p_sdo,
  input logic             cap_mode,
  input logic [1:0]       cap_rate,
  input logic [PCM_W-1:0] cap_word
);
  // R7
  a_out_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(a_sdo) |-> $past(a_rise || ce_fall));

  // R7
  p_out_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(p_sdo) |-> $past(p_rise || ce_fall));

  // R6
  frame_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ce_fall |=> (!a_sdo && !p_sdo));

  // R9
  one_pin_active_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_sdo, p_sdo}));

  // R1
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_fall |=> $stable({cap_mode, cap_rate, cap_word}));
endmodule

bind xcode_serial_if xcode_serial_if_chk #(.PCM_W(PCM_W)) u_chk (
  .clk(clk), .rst(rst), .ce_fall(ce_fall), .a_rise(a_rise), .p_rise(p_rise),
  .a_sdo(a_sdo), .p_sdo(p_sdo), .cap_mode(cap_mode), .cap_rate(cap_rate),
  .cap_word(cap_word));

// File: tb/sim_xcode_serial_if.sv
`timescale 1ns/1ps
module sim_xcode_serial_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, mode_i = 1'b0, a_sclk = 1'b0, a_sdi = 1'b0;
  logic p_sclk = 1'b0, p_sdi = 1'b0;
  logic [1:0] rate_i = 2'b00;
  logic a_sdo, p_sdo;

  always #2 clk = ~clk;  // 250 MHz

  xcode_serial_if u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .mode_i(mode_i), .rate_i(rate_i),
    .a_sclk(a_sclk), .a_sdi(a_sdi), .a_sdo(a_sdo),
    .p_sclk(p_sclk), .p_sdi(p_sdi), .p_sdo(p_sdo));

  typedef struct packed { logic [4:0] a; logic [7:0] p; } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];
  int checks = 0, fails = 0;
  logic [4:0] act_a;
  logic [7:0] act_p;
  event frame_done;
  bit done = 0;

  // bench model of the two-frame pipeline (R1)
  exp_t       nxt = '0;
  logic [4:0] prev_code = '0;
  logic [7:0] prev_pcm = '0;
  string      nxt_tag = "R8";

  function automatic int blen(logic [1:0] r);  // R2
    case (r)
      2'b00: return 4;
      2'b01: return 3;
      2'b10: return 2;
      default: return 5;
    endcase
  endfunction

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(logic md, logic [1:0] rt, logic [7:0] pcm, logic [4:0] code);
    int L;
    logic [4:0] al, m;
    exp_q.push_back(nxt);
    tag_q.push_back(nxt_tag);
    L = blen(rt);
    m = ~(5'h1F >> L);
    if (!md) begin  // decode R3 R4
      al  = prev_code << (5 - L);
      nxt = '{a: 5'h00, p: ({al, 3'b000} ^ 8'hA5)};
      nxt_tag = "R1 R2 R3 R4 R6 R9";
    end else begin  // encode R5
      nxt = '{a: ((prev_pcm[7:3] ^ 5'h15) & m), p: 8'h00};
      nxt_tag = "R1 R2 R5 R6 R9";
    end
    prev_code = code;
    prev_pcm  = pcm;
    mode_i = md;
    rate_i = rt;
    wclk(2);
    ce_n = 1'b0;
    wclk(8);
    ce_n = 1'b1;
    wclk(4);
    act_a = '0;
    act_p = '0;
    // R7: outputs sampled 7 cycles after each rise, inputs held 8 cycles to the fall
    for (int i = 0; i < 5; i++) begin
      a_sdi = code[4-i];
      a_sclk = 1'b1;
      wclk(7);
      act_a[4-i] = a_sdo;
      wclk(1);
      a_sclk = 1'b0;
      wclk(8);
    end
    for (int i = 0; i < 8; i++) begin
      p_sdi = pcm[7-i];
      p_sclk = 1'b1;
      wclk(7);
      act_p[7-i] = p_sdo;
      wclk(1);
      p_sclk = 1'b0;
      wclk(8);
    end
    -> frame_done;
    wclk(1);
  endtask

  // monitor: pops expected patterns as frames complete
  always @(frame_done) begin
    exp_t e;
    string t;
    if (exp_q.size() == 0) begin
      fails++;
      checks++;
      $display("FAIL R1 queue empty act_a=%h act_p=%h exp=none", act_a, act_p);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks += 2;
      if (act_a !== e.a) begin
        fails++;
        $display("FAIL %s a_sdo act=%h exp=%h", t, act_a, e.a);
      end
      if (act_p !== e.p) begin
        fails++;
        $display("FAIL %s p_sdo act=%h exp=%h", t, act_p, e.p);
      end
    end
  end

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(3);
    checks++;  // R8 reset state
    if (a_sdo !== 1'b0 || p_sdo !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset act=%b%b exp=00", a_sdo, p_sdo);
    end
    run_frame(0, 2'b00, 8'h3C, 5'h1A);
    run_frame(0, 2'b01, 8'hC3, 5'h0F);
    run_frame(0, 2'b10, 8'h81, 5'h15);
    run_frame(0, 2'b11, 8'h7E, 5'h1F);
    run_frame(1, 2'b00, 8'hF0, 5'h0A);
    run_frame(1, 2'b01, 8'h96, 5'h13);
    run_frame(1, 2'b10, 8'hFF, 5'h00);
    run_frame(1, 2'b11, 8'h00, 5'h11);
    run_frame(0, 2'b11, 8'h5A, 5'h1E);
    run_frame(1, 2'b10, 8'hA7, 5'h07);
    run_frame(0, 2'b01, 8'h18, 5'h16);
    run_frame(1, 2'b00, 8'h6D, 5'h09);
    run_frame(0, 2'b00, 8'h00, 5'h00);
    run_frame(0, 2'b10, 8'h00, 5'h00);
    wclk(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule